// File: doc/BRIEF.md
# Scan-Row Three-Level Output Selector with Blanking Control

This block turns, for each row channel of a passive-matrix display, the bit held in the scan latch and the frame-alternation polarity `fr` into a 2-bit level code. The code tells the analog output stage to drive the row to the high select rail, the low select rail or the mid non-select rail. Which select rail a selected row uses depends on the polarity, so the drive is AC-balanced over frames. A channel that is not selected always sits at mid.

Two blanking policies exist, chosen by the static pin `dms`. With `dms` high, the active-low off input `dspof_n` blanks every channel and is passed straight to `doc_n`, which tells the column drivers to blank as well. With `dms` low, the block starts blanked after reset. It counts serial entries, which are falling edges of the line clock `lp` that carry a data strobe. When 16 entries have been counted it unblanks and raises `doc_n`. In both policies a low `dspof_n` forces every channel to mid.

The policy is held by a two-state machine. `ST_BLANK` is the state after reset. It moves to `ST_SHOW` on the entry that brings the count to 16 (transition "entries complete"). `ST_SHOW` has no exit except reset.

Top module: `row_level_sel`

## Requirements
- R1: Each channel's 2-bit code (channel c at bits 2c+1:2c) is 2'b00 for mid, 2'b01 for high select or 2'b10 for low select. The value 2'b11 never appears.
- R2: When the display is enabled, a channel with latch bit 1 and `fr`=0 outputs 2'b01 (high select).
- R3: When the display is enabled, a channel with latch bit 1 and `fr`=1 outputs 2'b10 (low select).
- R4: A channel with latch bit 0 outputs 2'b00 for either value of `fr`.
- R5: While `dspof_n` is 0, every channel outputs 2'b00 in both policies. This does not disturb the entry count. Outputs follow the latch again in the same cycle that `dspof_n` returns to 1.
- R6: With `dms`=1, `doc_n` equals `dspof_n` in the same cycle, and the entry count has no effect on the outputs.
- R7: With `dms`=0, every channel outputs 2'b00 until 16 entries have been counted. An entry is a clock edge at which `lp` is 0, `lp` was 1 at the previous edge, and `din_stb` is 1. Outputs are enabled from the cycle after the 16th entry.
- R8: With `dms`=0, `doc_n` is 0 while fewer than 16 entries have been counted and 1 from the cycle after the 16th. It then stays 1 until reset, because the count saturates at 16.
- R9: A falling edge of `lp` with `din_stb`=0 is not counted. Holding `lp` low for several cycles counts at most one entry.
- R10: A reset (`rst_n`=0) clears the entry count and returns the block to the blanked state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp | input | 1 | Line clock, sampled on `clk` |
| din_stb | input | 1 | Serial data present on this `lp` fall |
| dms | input | 1 | Blanking policy: 1 = follow `dspof_n`, 0 = wait for 16 entries |
| dspof_n | input | 1 | Active-low display off |
| fr | input | 1 | Frame alternation polarity |
| latch | input | NCH | Scan latch bits, one per channel |
| lvl | output | 2*NCH | Level codes, two bits per channel |
| doc_n | output | 1 | Active-low blanking request to the column drivers |

## Verification
On every cycle the checker confirms that no channel shows the 2'b11 code. It also confirms that unselected channels sit at mid, that select polarity follows `fr` whenever the display is enabled, and that an off input or the blanked state forces all channels to mid. It further checks that `doc_n` follows `dspof_n` or the state (depending on `dms`), and that `ST_SHOW` is never left. Other properties only show up when the bench plays out sequences. These are that exactly the 16th strobed fall unblanks the display, that unstrobed and held-low `lp` periods are not counted, that turning the display off and on does not lose the count, and that reset starts the count over.

// File: rtl/row_lvl_pkg.sv
package row_lvl_pkg;

    typedef enum logic [1:0] {
        LV_MID = 2'b00,
        LV_HI  = 2'b01,
        LV_LO  = 2'b10
    } lvl_e;

    typedef enum logic {
        ST_BLANK = 1'b0,
        ST_SHOW  = 1'b1
    } blank_st_e;

endpackage

// File: rtl/lp_fall_det.sv
module lp_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lp,
    input  logic din_stb,
    output logic entry
);

    logic lp_q;

    // lp_q resets low so that lp already low at reset is not seen as a fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lp_q <= 1'b0;
        end else begin
            lp_q <= lp;
        end
    end

    always_comb begin
        entry = lp_q & ~lp & din_stb;
    end

endmodule

// File: rtl/blank_fsm.sv
module blank_fsm
    import row_lvl_pkg::*;
#(
    parameter int TARGET = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic entry,
    output logic show
);

    localparam int CW = $clog2(TARGET + 1);
    localparam logic [CW-1:0] LAST = CW'(TARGET - 1);
    localparam logic [CW-1:0] FULL = CW'(TARGET);

    blank_st_e st_q, st_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_BLANK;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (entry && (cnt_q != FULL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_BLANK: if (entry && (cnt_q == LAST)) st_d = ST_SHOW;
            ST_SHOW:  st_d = ST_SHOW;
            default:  st_d = ST_BLANK;
        endcase
    end

    always_comb begin
        show = (st_q == ST_SHOW);
    end

endmodule

// File: rtl/lvl_decode.sv
module lvl_decode
    import row_lvl_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0]   latch,
    input  logic             fr,
    input  logic             force_mid,
    output logic [2*NCH-1:0] lvl
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        lvl_e code;
        always_comb begin
            if (force_mid || !latch[c]) begin
                code = LV_MID;
            end else if (fr) begin
                code = LV_LO;
            end else begin
                code = LV_HI;
            end
        end
        assign lvl[2*c+1:2*c] = code;
    end

endmodule

// File: rtl/row_level_sel.sv
module row_level_sel #(
    parameter int NCH    = 8,
    parameter int TARGET = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lp,
    input  logic             din_stb,
    input  logic             dms,
    input  logic             dspof_n,
    input  logic             fr,
    input  logic [NCH-1:0]   latch,
    output logic [2*NCH-1:0] lvl,
    output logic             doc_n
);

    logic entry;
    logic show;
    logic force_mid;

    lp_fall_det u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .lp      (lp),
        .din_stb (din_stb),
        .entry   (entry)
    );

    blank_fsm #(.TARGET(TARGET)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .entry (entry),
        .show  (show)
    );

    always_comb begin
        force_mid = ~dspof_n | (~dms & ~show);
        doc_n     = dms ? dspof_n : show;
    end

    lvl_decode #(.NCH(NCH)) u_dec (
        .latch     (latch),
        .fr        (fr),
        .force_mid (force_mid),
        .lvl       (lvl)
    );

endmodule

// File: rtl/row_level_sel_chk.sv
module row_level_sel_chk #(
    parameter int NCH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dms,
    input logic             dspof_n,
    input logic             fr,
    input logic [NCH-1:0]   latch,
    input logic [2*NCH-1:0] lvl,
    input logic             doc_n,
    input logic             show
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        a_r1_no_code11: assert property (@(posedge clk) disable iff (!rst_n)
            lvl[2*c+1:2*c] != 2'b11);
        a_r4_unsel_mid: assert property (@(posedge clk) disable iff (!rst_n)
            !latch[c] |-> lvl[2*c+1:2*c] == 2'b00);
        a_r2_sel_hi: assert property (@(posedge clk) disable iff (!rst_n)
            (dspof_n && (dms || show) && latch[c] && !fr) |-> lvl[2*c+1:2*c] == 2'b01);
        a_r3_sel_lo: assert property (@(posedge clk) disable iff (!rst_n)
            (dspof_n && (dms || show) && latch[c] && fr) |-> lvl[2*c+1:2*c] == 2'b10);
    end

    a_r5_off_mid: assert property (@(posedge clk) disable iff (!rst_n)
        !dspof_n |-> lvl == '0);
    a_r6_doc_follow: assert property (@(posedge clk) disable iff (!rst_n)
        dms |-> doc_n == dspof_n);
    a_r7_blank_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (!dms && !show) |-> lvl == '0);
    a_r8_doc_state: assert property (@(posedge clk) disable iff (!rst_n)
        !dms |-> doc_n == show);
    a_r8_show_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        show |=> show);

endmodule

bind row_level_sel row_level_sel_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dms     (dms),
    .dspof_n (dspof_n),
    .fr      (fr),
    .latch   (latch),
    .lvl     (lvl),
    .doc_n   (doc_n),
    .show    (show)
);

// File: tb/row_level_sel_tb_top.sv
module row_level_sel_tb_top;

    localparam int NCH = 8;
    localparam int TGT = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp = 1'b1;
    logic din_stb = 1'b0;
    logic dms = 1'b0;
    logic dspof_n = 1'b1;
    logic fr = 1'b0;
    logic [NCH-1:0] latch = '0;
    logic [2*NCH-1:0] lvl;
    logic doc_n;

    int n_vec = 0;
    int n_bad = 0;
    int mdl_cnt = 0;

    always #2.5 clk = ~clk;

    row_level_sel #(.NCH(NCH), .TARGET(TGT)) dut_i (
        .clk(clk), .rst_n(rst_n), .lp(lp), .din_stb(din_stb), .dms(dms),
        .dspof_n(dspof_n), .fr(fr), .latch(latch), .lvl(lvl), .doc_n(doc_n)
    );

    function automatic logic [2*NCH-1:0] exp_lvl(input logic [NCH-1:0] l, input logic f,
                                                 input logic off_n, input logic m, input int cnt);
        logic [2*NCH-1:0] r = '0;
        logic blank = !off_n || (!m && cnt < TGT);
        for (int c = 0; c < NCH; c++) begin
            if (!blank && l[c]) r[2*c +: 2] = f ? 2'b10 : 2'b01;
        end
        return r;
    endfunction

    task automatic chk(input string rq);
        logic [2*NCH-1:0] el = exp_lvl(latch, fr, dspof_n, dms, mdl_cnt);
        logic ed = dms ? dspof_n : (mdl_cnt >= TGT);
        n_vec++;
        if (lvl !== el || doc_n !== ed) begin
            n_bad++;
            $display("FAIL %s: lvl=%h doc_n=%b expected lvl=%h doc_n=%b",
                     rq, lvl, doc_n, el, ed);
        end
    endtask

    task automatic sweep(input string rq);
        for (int p = 0; p < (1 << NCH); p++) begin
            for (int f = 0; f < 2; f++) begin
                @(negedge clk);
                latch = NCH'(p);
                fr = f[0];
                #1 chk(rq);
            end
        end
    endtask

    task automatic pulse(input logic stb);
        @(negedge clk); lp = 1'b1; din_stb = 1'b0;
        @(negedge clk); lp = 1'b0; din_stb = stb;
        @(negedge clk); lp = 1'b1; din_stb = 1'b0;
        if (stb && mdl_cnt < TGT) mdl_cnt++;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; mdl_cnt = 0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        latch = '1;
        do_reset();
        #1 chk("R10 reset blank");

        // dms high: polarity decode and off follow, count irrelevant
        dms = 1'b1;
        dspof_n = 1'b1; sweep("R2 R3 R4 R6 R1 dms-high on");
        dspof_n = 1'b0; sweep("R5 R6 dms-high off");
        dspof_n = 1'b1;

        // dms low: unstrobed falls are ignored
        dms = 1'b0; latch = '1;
        for (int i = 0; i < 10; i++) pulse(1'b0);
        #1 chk("R9 unstrobed falls");
        // held low counts once
        @(negedge clk); lp = 1'b1;
        @(negedge clk); lp = 1'b0; din_stb = 1'b1;
        repeat (5) @(negedge clk);
        lp = 1'b1; din_stb = 1'b0; mdl_cnt++;
        #1 chk("R9 held low");
        for (int i = 0; i < 14; i++) begin
            pulse(1'b1);
            #1 chk("R7 R8 below count");
        end
        fr = 1'b0; #1 chk("R7 fifteen entries still blank");
        dspof_n = 1'b0; @(negedge clk); #1 chk("R5 off while blank");
        dspof_n = 1'b1; @(negedge clk); #1 chk("R5 count kept");
        pulse(1'b1);
        #1 chk("R7 R8 sixteenth entry");
        sweep("R2 R3 R4 R7 dms-low shown");
        for (int i = 0; i < 4; i++) pulse(1'b1);
        #1 chk("R8 saturate");
        latch = 8'hA5; fr = 1'b1;
        dspof_n = 1'b0; @(negedge clk); #1 chk("R5 off in dms-low");
        dspof_n = 1'b1; #1 chk("R5 release immediate");

        do_reset();
        latch = '1;
        #1 chk("R10 reset mid-run");
        pulse(1'b1);
        #1 chk("R10 count restarted");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule